// File: doc/BRIEF.md
# Serial EEPROM Sequential Read Engine

This block is the slave-side read path of a byte-addressed serial EEPROM on a two-wire bus. A front end has already turned the raw lines into single-cycle event pulses: start condition, stop condition, SCL rising edge and SCL falling edge. It also provides the sampled SDA level. The engine recognises the device select byte. In the write direction it accepts a two-byte address that sets its address pointer. In the read direction it streams array bytes, most significant bit first, from that pointer. The pointer advances after every byte that the master acknowledges. It wraps from the top of the array back to zero, and the stream carries on without a break.

The engine drives SDA only as an open-drain pull-down enable. It pulls low for zero data bits and for its own acknowledges. It releases the line for one data bits, during the master's acknowledge clock, after a no-acknowledge, and whenever it is not addressed. A start condition at any point aborts whatever transfer is in progress and returns the engine to select-byte reception. The pointer keeps its value, so a following current-address read continues from where the stream stopped.

The array sits outside the block behind a synchronous read port with one cycle of latency. The front end must leave at least two clock cycles between an SCL rising pulse and the next SCL falling pulse.

Top module: `eeprom_seqrd`

## Requirements
- R1: While reset is held, and after it is released, `sda_oe` is 0 and `mem_rd_addr` is 0.
- R2: A select byte whose top four bits are 1010 and whose bits 3..1 equal `CHIP_SEL` is acknowledged. `sda_oe` is 1 from the cycle after the eighth SCL falling pulse to the cycle after the ninth. Any other select byte gets no acknowledge, and `sda_oe` stays 0 until the next start condition.
- R3: After a matching select byte with bit 0 = 0, two address bytes follow and each is acknowledged. The low bits of the first byte (bits AW-9..0) and the whole second byte load the pointer, and `mem_rd_addr` shows the new value one cycle after the eighth falling pulse of the second byte. The upper bits of the first byte are ignored, and a further byte in this direction is not acknowledged.
- R4: After a matching select byte with bit 0 = 1, the engine sends the byte stored at the pointer, bit 7 first. From the cycle after each SCL falling pulse, `sda_oe` equals the inverse of the bit being sent.
- R5: If `sda_in` is 0 at the SCL rising pulse of the ninth clock, the pointer advances by one, and the next byte is driven from the cycle after the following falling pulse.
- R6: Stepping from address MEM_BYTES-1 gives address 0, and the stream continues across the wrap.
- R7: If `sda_in` is 1 at the ninth rising pulse, the engine stays released until a start or stop condition, and the pointer does not advance.
- R8: A start condition during any transfer releases `sda_oe` in the next cycle and returns to select-byte reception. The pointer keeps its value.
- R9: `sda_oe` is 0 throughout the master's acknowledge clock after each data byte.
- R10: `sda_oe` changes only in the cycle after an SCL falling pulse, a start pulse or a stop pulse, so it holds steady while SCL is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_evt | input | 1 | One-cycle pulse for a detected start condition |
| stop_evt | input | 1 | One-cycle pulse for a detected stop condition |
| scl_rise | input | 1 | One-cycle pulse on an SCL rising edge |
| scl_fall | input | 1 | One-cycle pulse on an SCL falling edge |
| sda_in | input | 1 | Sampled SDA level, valid at `scl_rise` |
| mem_rd_addr | output | AW | Array read address, equal to the address pointer |
| mem_rd_data | input | 8 | Array read data, one cycle after `mem_rd_addr` |
| sda_oe | output | 1 | Open-drain enable, 1 pulls SDA low |

## Verification
Every result of this engine is registered once, so each one is due in the cycle after the event pulse that causes it. The SDA enable follows a falling, start or stop pulse. The pointer follows the acknowledge rising pulse or the final address falling pulse. Array data is fetched early enough to be ready at the next falling pulse. The bench drives each pulse for one cycle from the falling clock edge, and it updates its expected SDA enable at the moment it withdraws the pulse. It compares that expectation with the design shortly after every falling clock edge, so both the change and the steady hold are checked each cycle. Pointer values are checked at the ports once each transfer settles.

// File: rtl/seqrd_pkg.sv
package seqrd_pkg;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_AHI,
    ST_AHI_ACK,
    ST_ALO,
    ST_ALO_ACK,
    ST_RD_DATA,
    ST_RD_ACK,
    ST_RD_NEXT,
    ST_HOLD
  } st_e;

endpackage

// File: rtl/seqrd_rx_shift.sv
module seqrd_rx_shift
  import seqrd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              sample,
  input  logic              bit_in,
  output logic [BYTE_W-1:0] byte_q,
  output logic              full
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      byte_q <= '0;
      cnt_q  <= '0;
    end else if (clear) begin
      cnt_q  <= '0;
    end else if (sample) begin
      byte_q <= {byte_q[BYTE_W-2:0], bit_in};
      if (cnt_q != CNT_W'(BYTE_W))
        cnt_q <= cnt_q + 1'b1;
    end
  end

  assign full = (cnt_q == CNT_W'(BYTE_W));

endmodule

// File: rtl/seqrd_tx_drive.sv
module seqrd_tx_drive
  import seqrd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              release_bus,
  input  logic              ack_low,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_data,
  input  logic              shift,
  output logic              oe_q
);

  logic [BYTE_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q <= '0;
      oe_q <= 1'b0;
    end else if (release_bus) begin
      oe_q <= 1'b0;
    end else if (ack_low) begin
      oe_q <= 1'b1;
    end else if (load) begin
      sh_q <= load_data;
      oe_q <= ~load_data[BYTE_W-1];
    end else if (shift) begin
      sh_q <= {sh_q[BYTE_W-2:0], 1'b0};
      oe_q <= ~sh_q[BYTE_W-2];
    end
  end

endmodule

// File: rtl/seqrd_addr_ptr.sv
module seqrd_addr_ptr #(
  parameter int MEM_BYTES = 4096,
  localparam int AW = $clog2(MEM_BYTES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic          step,
  output logic [AW-1:0] ptr_q
);

  localparam logic [AW-1:0] LAST = AW'(MEM_BYTES - 1);

  always_ff @(posedge clk) begin
    if (rst)
      ptr_q <= '0;
    else if (load)
      ptr_q <= load_addr;
    else if (step)
      ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

endmodule

// File: rtl/eeprom_seqrd.sv
// Read engine of a serial EEPROM slave. MEM_BYTES must exceed 256 so that
// the first address byte carries at least one pointer bit.
module eeprom_seqrd #(
  parameter int         MEM_BYTES = 4096,
  parameter logic [2:0] CHIP_SEL  = 3'b000,
  localparam int        AW        = $clog2(MEM_BYTES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_evt,
  input  logic          stop_evt,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_in,
  output logic [AW-1:0] mem_rd_addr,
  input  logic [7:0]    mem_rd_data,
  output logic          sda_oe
);
  import seqrd_pkg::*;

  localparam int HI_W = AW - BYTE_W;

  st_e             st_q, st_d;
  logic            rw_q, rw_d;
  logic [HI_W-1:0] hi_q, hi_d;

  logic              rx_clr, rx_smp, rx_full;
  logic [BYTE_W-1:0] rx_byte;
  logic              tx_rel, tx_ack, tx_load, tx_shift;
  logic              ptr_load, ptr_step;
  logic              sel_ok;

  assign sel_ok = (rx_byte[7:4] == DEV_CODE) && (rx_byte[3:1] == CHIP_SEL);

  always_comb begin
    st_d     = st_q;
    rw_d     = rw_q;
    hi_d     = hi_q;
    rx_clr   = 1'b0;
    rx_smp   = 1'b0;
    tx_rel   = 1'b0;
    tx_ack   = 1'b0;
    tx_load  = 1'b0;
    tx_shift = 1'b0;
    ptr_load = 1'b0;
    ptr_step = 1'b0;
    if (start_evt) begin
      st_d   = ST_DEV;
      rx_clr = 1'b1;
      tx_rel = 1'b1;
    end else if (stop_evt) begin
      st_d   = ST_IDLE;
      rx_clr = 1'b1;
      tx_rel = 1'b1;
    end else begin
      case (st_q)
        ST_DEV: begin
          if (scl_rise) begin
            rx_smp = 1'b1;
          end else if (scl_fall && rx_full) begin
            if (sel_ok) begin
              tx_ack = 1'b1;
              rw_d   = rx_byte[0];
              st_d   = ST_DEV_ACK;
            end else begin
              st_d   = ST_HOLD;
            end
          end
        end
        ST_DEV_ACK: begin
          if (scl_fall) begin
            rx_clr = 1'b1;
            if (rw_q) begin
              tx_load = 1'b1;
              st_d    = ST_RD_DATA;
            end else begin
              tx_rel  = 1'b1;
              st_d    = ST_AHI;
            end
          end
        end
        ST_AHI: begin
          if (scl_rise) begin
            rx_smp = 1'b1;
          end else if (scl_fall && rx_full) begin
            tx_ack = 1'b1;
            hi_d   = rx_byte[HI_W-1:0];
            st_d   = ST_AHI_ACK;
          end
        end
        ST_AHI_ACK: begin
          if (scl_fall) begin
            rx_clr = 1'b1;
            tx_rel = 1'b1;
            st_d   = ST_ALO;
          end
        end
        ST_ALO: begin
          if (scl_rise) begin
            rx_smp = 1'b1;
          end else if (scl_fall && rx_full) begin
            tx_ack   = 1'b1;
            ptr_load = 1'b1;
            st_d     = ST_ALO_ACK;
          end
        end
        ST_ALO_ACK: begin
          if (scl_fall) begin
            tx_rel = 1'b1;
            st_d   = ST_HOLD;
          end
        end
        ST_RD_DATA: begin
          if (scl_rise) begin
            rx_smp = 1'b1;
          end else if (scl_fall) begin
            if (rx_full) begin
              tx_rel = 1'b1;
              rx_clr = 1'b1;
              st_d   = ST_RD_ACK;
            end else begin
              tx_shift = 1'b1;
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            if (!sda_in) begin
              ptr_step = 1'b1;
              st_d     = ST_RD_NEXT;
            end else begin
              st_d     = ST_HOLD;
            end
          end
        end
        ST_RD_NEXT: begin
          if (scl_fall) begin
            tx_load = 1'b1;
            st_d    = ST_RD_DATA;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_IDLE;
      rw_q <= 1'b0;
      hi_q <= '0;
    end else begin
      st_q <= st_d;
      rw_q <= rw_d;
      hi_q <= hi_d;
    end
  end

  seqrd_rx_shift u_rx (
    .clk    (clk),
    .rst    (rst),
    .clear  (rx_clr),
    .sample (rx_smp),
    .bit_in (sda_in),
    .byte_q (rx_byte),
    .full   (rx_full)
  );

  seqrd_tx_drive u_tx (
    .clk         (clk),
    .rst         (rst),
    .release_bus (tx_rel),
    .ack_low     (tx_ack),
    .load        (tx_load),
    .load_data   (mem_rd_data),
    .shift       (tx_shift),
    .oe_q        (sda_oe)
  );

  seqrd_addr_ptr #(.MEM_BYTES(MEM_BYTES)) u_ptr (
    .clk       (clk),
    .rst       (rst),
    .load      (ptr_load),
    .load_addr ({hi_q, rx_byte}),
    .step      (ptr_step),
    .ptr_q     (mem_rd_addr)
  );

endmodule

// File: rtl/seqrd_checker.sv
module seqrd_checker #(
  parameter int AW = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             start_evt,
  input logic             stop_evt,
  input logic             scl_rise,
  input logic             scl_fall,
  input logic             sda_in,
  input logic             sda_oe,
  input logic [AW-1:0]    mem_rd_addr,
  input seqrd_pkg::st_e   st
);
  import seqrd_pkg::*;

  logic ack_step;
  assign ack_step = (st == ST_RD_ACK) && scl_rise && !sda_in && !start_evt && !stop_evt;

  assert_oe_moves_on_fall_R10: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> $past(scl_fall || start_evt || stop_evt));

  assert_ptr_step_R5: assert property (@(posedge clk) disable iff (rst)
    $past(ack_step) |-> (mem_rd_addr == $past(mem_rd_addr) + 1'b1));

  assert_ptr_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(ack_step) && ($past(mem_rd_addr) == {AW{1'b1}})) |-> (mem_rd_addr == '0));

  assert_start_abort_R8: assert property (@(posedge clk) disable iff (rst)
    $past(start_evt) |-> (!sda_oe && st == ST_DEV));

  assert_ack_clock_free_R9: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_RD_ACK) && ($past(st) == ST_RD_ACK)) |-> !sda_oe);

  assert_nack_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HOLD && $past(st) == ST_HOLD) |-> (!sda_oe && $stable(mem_rd_addr)));

endmodule

bind eeprom_seqrd seqrd_checker #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start_evt   (start_evt),
  .stop_evt    (stop_evt),
  .scl_rise    (scl_rise),
  .scl_fall    (scl_fall),
  .sda_in      (sda_in),
  .sda_oe      (sda_oe),
  .mem_rd_addr (mem_rd_addr),
  .st          (st_q)
);

// File: tb/eeprom_seqrd_test.sv
module eeprom_seqrd_test;

  localparam int MEM = 4096;
  localparam int AW  = 12;
  localparam logic [7:0] RSEL = 8'b1010_000_1;
  localparam logic [7:0] WSEL = 8'b1010_000_0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_evt = 1'b0, stop_evt = 1'b0, scl_rise = 1'b0, scl_fall = 1'b0;
  logic sda_in = 1'b1;
  logic [AW-1:0] mem_rd_addr;
  logic [7:0]    mem_rd_data;
  logic          sda_oe;

  int    n_tests = 0;
  int    n_fail  = 0;
  int    ptr_m   = 0;
  logic  exp_oe  = 1'b0;
  bit    cmp_en  = 1'b0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  function automatic logic [7:0] memf(int a);
    return 8'((a * 29) + (a >> 7) + 3);
  endfunction

  always_ff @(posedge clk) mem_rd_data <= memf(int'(mem_rd_addr));

  eeprom_seqrd uut (
    .clk         (clk),
    .rst         (rst),
    .start_evt   (start_evt),
    .stop_evt    (stop_evt),
    .scl_rise    (scl_rise),
    .scl_fall    (scl_fall),
    .sda_in      (sda_in),
    .mem_rd_addr (mem_rd_addr),
    .mem_rd_data (mem_rd_data),
    .sda_oe      (sda_oe)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison of the SDA enable against the behavioural model
  always @(negedge clk) begin
    #1;
    if (cmp_en) chk(cur_req, int'(sda_oe), int'(exp_oe));
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic scl_bit(input logic mbit, input logic oe_after);
    sda_in = mbit;
    cyc(1);
    scl_rise = 1'b1; cyc(1); scl_rise = 1'b0;
    cyc(3);
    scl_fall = 1'b1; cyc(1); scl_fall = 1'b0; exp_oe = oe_after;
    cyc(1);
  endtask

  task automatic do_start;
    start_evt = 1'b1; cyc(1); start_evt = 1'b0; exp_oe = 1'b0;
    cyc(2);
    scl_fall = 1'b1; cyc(1); scl_fall = 1'b0;
    cyc(1);
  endtask

  task automatic do_stop;
    sda_in = 1'b1;
    scl_rise = 1'b1; cyc(1); scl_rise = 1'b0; cyc(2);
    stop_evt = 1'b1; cyc(1); stop_evt = 1'b0; exp_oe = 1'b0;
    cyc(2);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic ack, input logic oe_after_ack);
    for (int i = 7; i >= 0; i--) scl_bit(b[i], (i == 0) ? ack : 1'b0);
    scl_bit(1'b1, oe_after_ack);
  endtask

  task automatic read_one(input bit more);
    logic [7:0] d, nd;
    d = memf(ptr_m);
    for (int i = 7; i >= 1; i--) scl_bit(1'b1, ~d[i-1]);
    scl_bit(1'b1, 1'b0);
    if (more) begin
      ptr_m = (ptr_m + 1) % MEM;
      nd = memf(ptr_m);
      scl_bit(1'b0, ~nd[7]);
    end else begin
      scl_bit(1'b1, 1'b0);
    end
  endtask

  task automatic current_read(input int n);
    logic [7:0] d;
    do_start;
    d = memf(ptr_m);
    send_byte(RSEL, 1'b1, ~d[7]);
    for (int k = 0; k < n; k++) read_one(k < n - 1);
    do_stop;
  endtask

  task automatic set_addr(input int a, input logic [3:0] junk);
    do_start;
    send_byte(WSEL, 1'b1, 1'b0);
    send_byte({junk, 4'(a >> 8)}, 1'b1, 1'b0);
    send_byte(8'(a), 1'b1, 1'b0);
    ptr_m = a;
  endtask

  initial begin
    cyc(1);
    chk("R1", int'(sda_oe), 0);
    cyc(4);
    rst = 1'b0;
    cyc(1);
    chk("R1", int'(sda_oe), 0);
    chk("R1", int'(mem_rd_addr), 0);
    cmp_en = 1'b1;

    cur_req = "R4";
    current_read(3);
    chk("R7", int'(mem_rd_addr), 2);

    cur_req = "R7";
    do_start;
    send_byte(RSEL, 1'b1, ~memf(ptr_m)[7]);
    read_one(1'b0);
    scl_bit(1'b0, 1'b0);
    scl_bit(1'b1, 1'b0);
    chk("R7", int'(mem_rd_addr), ptr_m);
    do_stop;

    cur_req = "R3";
    set_addr(12'h123, 4'hA);
    chk("R3", int'(mem_rd_addr), 12'h123);
    send_byte(8'h00, 1'b0, 1'b0);
    chk("R3", int'(mem_rd_addr), 12'h123);
    cur_req = "R5";
    current_read(4);
    chk("R5", int'(mem_rd_addr), 12'h126);

    cur_req = "R6";
    set_addr(12'hFFE, 4'h0);
    chk("R3", int'(mem_rd_addr), 12'hFFE);
    current_read(5);
    chk("R6", int'(mem_rd_addr), 2);

    cur_req = "R2";
    do_start;
    send_byte(8'hB1, 1'b0, 1'b0);
    send_byte(RSEL, 1'b0, 1'b0);
    do_stop;
    do_start;
    send_byte(8'hA3, 1'b0, 1'b0);
    do_stop;
    chk("R2", int'(mem_rd_addr), 2);

    cur_req = "R8";
    do_start;
    send_byte(RSEL, 1'b1, ~memf(ptr_m)[7]);
    read_one(1'b1);
    for (int i = 7; i >= 5; i--) scl_bit(1'b1, ~memf(ptr_m)[i-1]);
    do_start;
    chk("R8", int'(sda_oe), 0);
    chk("R8", int'(mem_rd_addr), ptr_m);
    cur_req = "R9";
    send_byte(RSEL, 1'b1, ~memf(ptr_m)[7]);
    for (int k = 0; k < 2; k++) read_one(k < 1);
    do_stop;
    chk("R9", int'(mem_rd_addr), 4);

    cur_req = "R10";
    cyc(5);
    chk("R10", int'(sda_oe), 0);

    cmp_en = 1'b0;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule